// File: doc/BRIEF.md
# TDM Timeslot Switch with Per-Slot Action Table

This block handles a time-division-multiplexed sample stream one timeslot at a time. Every slot has a 20-bit entry in an action table: a 16-bit control word and a 4-bit channel number. The entry decides what happens to the incoming sample. The sample can be stored in a frame-sized switching memory, stored in one of sixteen channel buffers, or both. The entry also decides where the outgoing sample comes from: the previous frame's switching memory at a programmed slot index, a channel buffer, or nowhere (output disabled).

The switching memory has two banks, selected by frame parity. Writes for the current frame never disturb reads of the previous frame. The banks swap after the last slot of each frame.

A bypass lets the last slot of a frame be played in slot 0 of the next frame. There is no time to go through memory in that case, so the sample is taken straight from the input register.

The upstream framer gives one `slot_valid_i` strobe per timeslot, with the slot index and the parallel sample. The result appears on `sample_o`/`oe_o` one clock later. Software-side logic loads the table through a simple write port.

Top module: `tdm_slot_switch`

## Requirements
- R1: After reset `oe_o` and `sample_o` are 0, every action entry is zero (so every slot plays disabled), and all channel buffers read 0.
- R2: Control word bit 3 (store) writes the slot's incoming sample into the current frame's bank at the slot index. Bit 1 (switched play) outputs the previous frame's bank at the index in bits 14:5, taken modulo NUM_SLOTS.
- R3: Control word bit 4 (buffer store) writes the incoming sample into the channel buffer chosen by the 4-bit channel field. Bit 2 (buffer play) outputs that buffer's contents from before this slot's write.
- R4: When bits 2 and 1 are both set, the output comes from the channel buffer.
- R5: When bit 0 (drive) is 0, `oe_o` is 0 and `sample_o` is 0 for that slot, whatever the other bits are.
- R6: When bit 0 is 1 and bits 2 and 1 are both 0, `oe_o` is 1 and `sample_o` is all zeros.
- R7: When bit 15 (bypass) is set together with bit 1 and without bit 2, the output is the incoming sample of the previous valid slot, and bits 14:5 are ignored. If bit 3 is also set, the current sample is still stored.
- R8: Bit 15 has no effect when bit 1 is clear or bit 2 is set.
- R9: The banks swap after slot NUM_SLOTS-1. A switched read in frame k returns data stored in frame k-1, even when the source slot has already been written in frame k.
- R10: Outputs update on the clock after a `slot_valid_i` cycle and hold their value while `slot_valid_i` is low.
- R11: A table write takes effect for every slot processed after the write cycle, including later slots of the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | 1 | One-cycle strobe per timeslot |
| slot_i | input | SLOT_W | Current timeslot index |
| sample_i | input | SAMPLE_W | Incoming sample of the current timeslot |
| act_we_i | input | 1 | Action table write enable |
| act_addr_i | input | SLOT_W | Action table write address |
| act_word_i | input | 16 | Control word to write |
| act_ch_i | input | CH_W | Channel number to write |
| sample_o | output | SAMPLE_W | Outgoing sample |
| oe_o | output | 1 | Output drive enable (0 = high impedance) |

## Verification
Faults in the bank pointer or the switching memory show up one frame late. They appear as a switched slot playing data from the wrong frame, or as data appearing in the same frame. So the scoreboard runs several consecutive frames with a reference model of both banks.

A bad channel buffer or a wrong source priority shows up at the very next slot that plays that buffer.

A broken bypass register changes slot 0's output right away. To make that visible, the bypass slot's source field points elsewhere. Idle gaps in the middle of a frame expose any output that fails to hold.

// File: rtl/tdm_slot_switch_pkg.sv
package tdm_slot_switch_pkg;
  localparam int unsigned ACT_W = 16;

  typedef struct packed {
    logic       byp;    // last-slot bypass
    logic [9:0] src;    // source slot of previous frame
    logic       bstore; // store into channel buffer
    logic       sstore; // store into switching memory
    logic       bplay;  // play from channel buffer
    logic       splay;  // play from switching memory
    logic       drive;  // 0: tri-state
  } act_word_t;
endpackage

// File: rtl/tdm_act_table.sv
module tdm_act_table
  import tdm_slot_switch_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned CH_W      = 4,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] waddr_i,
  input  act_word_t         wact_i,
  input  logic [CH_W-1:0]   wch_i,
  input  logic [SLOT_W-1:0] raddr_i,
  output act_word_t         ract_o,
  output logic [CH_W-1:0]   rch_o
);
  act_word_t       act_q [NUM_SLOTS];
  logic [CH_W-1:0] ch_q  [NUM_SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        act_q[i] <= '0;
        ch_q[i]  <= '0;
      end
    end else if (we_i) begin
      act_q[waddr_i] <= wact_i;
      ch_q[waddr_i]  <= wch_i;
    end
  end

  assign ract_o = act_q[raddr_i];
  assign rch_o  = ch_q[raddr_i];
endmodule

// File: rtl/tdm_switch_mem.sv
module tdm_switch_mem #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned SAMPLE_W  = 8,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic                wbank_i,
  input  logic [SLOT_W-1:0]   waddr_i,
  input  logic [SAMPLE_W-1:0] wdata_i,
  input  logic                rbank_i,
  input  logic [SLOT_W-1:0]   raddr_i,
  output logic [SAMPLE_W-1:0] rdata_o
);
  logic [SAMPLE_W-1:0] mem_q [2][NUM_SLOTS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wbank_i][waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[rbank_i][raddr_i];
endmodule

// File: rtl/tdm_chan_buf.sv
module tdm_chan_buf #(
  parameter int unsigned CH_W     = 4,
  parameter int unsigned SAMPLE_W = 8,
  localparam int unsigned NUM_CH  = 1 << CH_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [CH_W-1:0]     waddr_i,
  input  logic [SAMPLE_W-1:0] wdata_i,
  input  logic [CH_W-1:0]     raddr_i,
  output logic [SAMPLE_W-1:0] rdata_o
);
  logic [SAMPLE_W-1:0] buf_q [NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) buf_q[i] <= '0;
    end else if (we_i) begin
      buf_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = buf_q[raddr_i];
endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch
  import tdm_slot_switch_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,  // power of two, 2..1024
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned CH_W      = 4,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                slot_valid_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                act_we_i,
  input  logic [SLOT_W-1:0]   act_addr_i,
  input  logic [ACT_W-1:0]    act_word_i,
  input  logic [CH_W-1:0]     act_ch_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                oe_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  act_word_t           act;
  logic [CH_W-1:0]     act_ch;
  logic [SAMPLE_W-1:0] sw_rd, buf_rd, nxt_sample;
  logic [SAMPLE_W-1:0] in_q, out_q;
  logic                bank_q, oe_q;

  tdm_act_table #(.NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W)) u_act (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (act_we_i),
    .waddr_i (act_addr_i),
    .wact_i  (act_word_t'(act_word_i)),
    .wch_i   (act_ch_i),
    .raddr_i (slot_i),
    .ract_o  (act),
    .rch_o   (act_ch)
  );

  tdm_switch_mem #(.NUM_SLOTS(NUM_SLOTS), .SAMPLE_W(SAMPLE_W)) u_sw (
    .clk_i   (clk_i),
    .we_i    (slot_valid_i && act.sstore),
    .wbank_i (bank_q),
    .waddr_i (slot_i),
    .wdata_i (sample_i),
    .rbank_i (~bank_q),
    .raddr_i (act.src[SLOT_W-1:0]),
    .rdata_o (sw_rd)
  );

  tdm_chan_buf #(.CH_W(CH_W), .SAMPLE_W(SAMPLE_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (slot_valid_i && act.bstore),
    .waddr_i (act_ch),
    .wdata_i (sample_i),
    .raddr_i (act_ch),
    .rdata_o (buf_rd)
  );

  // buffer beats switched; bypass only on the switched path
  always_comb begin
    nxt_sample = '0;
    if (act.drive) begin
      if (act.bplay)      nxt_sample = buf_rd;
      else if (act.splay) nxt_sample = act.byp ? in_q : sw_rd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      oe_q   <= 1'b0;
      in_q   <= '0;
      bank_q <= 1'b0;
    end else if (slot_valid_i) begin
      out_q <= nxt_sample;
      oe_q  <= act.drive;
      in_q  <= sample_i;
      if (slot_i == LAST_SLOT) bank_q <= ~bank_q;
    end
  end

  assign sample_o = out_q;
  assign oe_o     = oe_q;
endmodule

// File: rtl/tdm_slot_switch_chk.sv
module tdm_slot_switch_chk #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned SLOT_W   = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                slot_valid_i,
  input logic [SLOT_W-1:0]   slot_i,
  input logic                drive,
  input logic                bplay,
  input logic [SAMPLE_W-1:0] buf_rd,
  input logic                bank_q,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                oe_o
);
  AST_DRIVE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_i && !drive |=> !oe_o) else $error("drive off"); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> sample_o == '0) else $error("idle nonzero"); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_valid_i |=> $stable(sample_o) && $stable(oe_o)) else $error("hold"); // R10
  AST_BANK_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_i && slot_i == SLOT_W'((1 << SLOT_W) - 1) |=> bank_q != $past(bank_q))
    else $error("bank swap"); // R9
  AST_BANK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_valid_i |=> $stable(bank_q)) else $error("bank keep"); // R9
  AST_BUF_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_i && drive && bplay |=> sample_o == $past(buf_rd)) else $error("buf"); // R4
endmodule

bind tdm_slot_switch tdm_slot_switch_chk #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .slot_valid_i (slot_valid_i),
  .slot_i       (slot_i),
  .drive        (act.drive),
  .bplay        (act.bplay),
  .buf_rd       (buf_rd),
  .bank_q       (bank_q),
  .sample_o     (sample_o),
  .oe_o         (oe_o)
);

// File: tb/tdm_slot_switch_tb_top.sv
module tdm_slot_switch_tb_top;
  localparam int NS = 32;
  localparam int SW = 5;
  localparam logic [15:0] BYP = 16'h8000, BST = 16'h0010, SST = 16'h0008,
                          BPL = 16'h0004, SPL = 16'h0002, DRV = 16'h0001;

  logic clk = 0, rst_ni = 0;
  logic slot_valid = 0, act_we = 0;
  logic [SW-1:0] slot = '0, act_addr = '0;
  logic [7:0] sample = '0;
  logic [15:0] act_word = '0;
  logic [3:0] act_ch = '0;
  logic [7:0] sample_o;
  logic oe_o;

  always #10 clk = ~clk;

  tdm_slot_switch #(.NUM_SLOTS(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .slot_valid_i(slot_valid), .slot_i(slot),
    .sample_i(sample), .act_we_i(act_we), .act_addr_i(act_addr),
    .act_word_i(act_word), .act_ch_i(act_ch), .sample_o(sample_o), .oe_o(oe_o));

  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  string req_q[$];
  logic [8:0] last_exp = '0;
  logic pend = 0;

  // reference model
  logic [7:0]  mmem [2][NS];
  logic [15:0] mact [NS];
  logic [3:0]  mch  [NS];
  logic [7:0]  mbuf [16];
  logic mbank = 0;
  logic [7:0] min_q = '0;

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got oe=%0b data=%02h expected oe=%0b data=%02h",
               req, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  always @(posedge clk) pend <= slot_valid;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [8:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      last_exp = e;
      check(r, {oe_o, sample_o}, e);
    end
  end

  task automatic write_act(int s, logic [15:0] w, logic [3:0] ch);
    @(negedge clk);
    slot_valid = 0;
    act_we = 1; act_addr = SW'(s); act_word = w; act_ch = ch;
    mact[s] = w; mch[s] = ch;
    @(negedge clk);
    act_we = 0;
  endtask

  task automatic run_slot(int s, logic [7:0] smp, string pre);
    logic [15:0] a;
    logic [7:0] d;
    string tag;
    a = mact[s];
    d = 8'h00;
    if (!a[0])      tag = "R5";
    else if (a[2])  tag = a[15] ? "R8" : (a[1] ? "R4" : "R3");
    else if (a[1])  tag = a[15] ? "R7" : "R2";
    else            tag = a[15] ? "R8" : "R6";
    if (a[0]) begin
      if (a[2])      d = mbuf[mch[s]];
      else if (a[1]) d = a[15] ? min_q : mmem[~mbank][int'(a[14:5]) % NS];
    end
    exp_q.push_back({a[0], d});
    req_q.push_back({pre, tag});
    if (a[3]) mmem[mbank][s] = smp;
    if (a[4]) mbuf[mch[s]] = smp;
    min_q = smp;
    if (s == NS - 1) mbank = ~mbank;
    @(negedge clk);
    act_we = 0; slot_valid = 1; slot = SW'(s); sample = smp;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      slot_valid = 0;
    end
  endtask

  function automatic logic [7:0] smp_of(int f, int s);
    return 8'((f * 37 + s * 5 + 1) & 8'hff);
  endfunction

  task automatic run_range(int f, int lo, int hi, string pre);
    for (int s = lo; s <= hi; s++) run_slot(s, smp_of(f, s), pre);
  endtask

  task automatic program_main();
    for (int s = 0; s < NS; s++)
      write_act(s, SST | SPL | DRV | 16'(((s + 1) % NS) << 5), 4'd0);
    write_act(0, BYP | SPL | DRV | SST | 16'(5 << 5), 4'd0);
    write_act(1, SPL | DRV | SST | 16'(7 << 5), 4'd0);
    write_act(2, BST | SST | DRV, 4'd3);
    write_act(3, BPL | DRV | SST, 4'd3);
    write_act(4, BPL | SPL | DRV | SST | 16'(9 << 5), 4'd3);
    write_act(5, BYP | SPL | BPL | DRV | SST, 4'd3);
    write_act(6, BYP | DRV | SST, 4'd0);
    write_act(7, SPL | SST | 16'(2 << 5), 4'd0);
    write_act(8, BPL | DRV | SST, 4'd15);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin mact[i] = '0; mch[i] = '0; end
    for (int i = 0; i < 16; i++) mbuf[i] = '0;
    #1;
    check("R1 reset", {oe_o, sample_o}, 9'h000);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    check("R1 after release", {oe_o, sample_o}, 9'h000);
    // R1: unprogrammed slot plays disabled
    run_slot(0, 8'hA5, "R1 ");
    idle(2);
    // frame 0: store everything, drive zeros (R6)
    for (int s = 0; s < NS; s++) write_act(s, SST | DRV, 4'd0);
    run_range(0, 1, NS - 1, "");
    idle(1);
    run_range(0, 0, NS - 1, "R6 ");
    // frame 1: mixed actions (R2 R3 R4 R5 R7 R8)
    program_main();
    run_range(1, 0, NS - 1, "");
    // frame 2: same table, previous-frame data (R9), idle gap (R10)
    run_range(2, 0, 10, "R9 ");
    idle(3);
    check("R10 hold", {oe_o, sample_o}, last_exp);
    run_range(2, 11, NS - 1, "R9 ");
    // frame 3: table changes (R11)
    write_act(1, BPL | DRV | SST, 4'd3);
    run_range(3, 0, 10, "R11 ");
    write_act(20, SPL | DRV | SST | 16'(0 << 5), 4'd0);
    run_range(3, 11, NS - 1, "R11 ");
    idle(3);
    if (exp_q.size() != 0) check("R10 drain", 9'(exp_q.size()), 9'h000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule